// File: doc/BRIEF.md
# Line Signal Loss and Transmit Clock Watchdog

This block monitors a line interface in both directions. On the receive side it counts consecutive zero bits in the recovered bit stream, qualified by a bit strobe, and raises a loss-of-signal flag once the run reaches a configured length. The flag drops on the first received mark on either rail. Each change of the flag, in either direction, sets a pending interrupt that stays high until the host clears it. A host mask level prevents new changes from setting it.

On the transmit side it samples the transmit clock with the free-running reference clock. It counts reference cycles that pass without a rising transmit clock edge. When that count reaches the configured number of unit intervals, the block disables the line driver so that nothing is transmitted. The first rising edge after the clock returns re-enables the driver. A host request input also disables the driver, at any time and independent of the clock.

Top module: `los_txmon`

## Requirements
- R1: With the default ZERO_LIMIT of 175, `los_o` goes to 1 on the cycle after the strobe of the 175th consecutive zero bit. After 174 zeros it is still 0. Cycles without `rx_strobe_i` are not counted.
- R2: A strobed bit with `rx_pos_i` or `rx_neg_i` high (a mark on either rail) clears `los_o` on the next cycle and restarts the zero run from zero.
- R3: With `los_mask_i` low, every change of `los_o` (0 to 1 or 1 to 0) sets `irq_o` one cycle after `los_o` changes.
- R4: `irq_o` stays at 1 until `int_clr_i` is high for a cycle. It is 0 on the following cycle unless a new unmasked change arrives in that same cycle, in which case the new change wins.
- R5: While `los_mask_i` is high, changes of `los_o` do not set `irq_o`. `los_o` itself still follows R1 and R2.
- R6: If `tx_clk_i` shows no rising edge for ZERO_LIMIT*REF_PER_UI reference cycles (700 by default), `drv_off_o` goes to 1. It stays 0 while rising edges keep arriving more often than that.
- R7: After the driver has been disabled by R6, the first rising edge of `tx_clk_i` clears that disable within 4 reference cycles. This includes 2 synchronizer stages and the edge register.
- R8: `tx_hiz_req_i` high forces `drv_off_o` to 1 in the same cycle, whether or not the transmit clock is running. When the request is released and the clock is running, `drv_off_o` returns to 0.
- R9: While `rst_ni` is low, `los_o`, `irq_o` and `drv_off_o` are 0 and both counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_strobe_i | input | 1 | One-cycle strobe marking a valid received bit |
| rx_pos_i | input | 1 | Positive-rail mark of the received bit |
| rx_neg_i | input | 1 | Negative-rail mark of the received bit |
| tx_clk_i | input | 1 | Transmit clock, asynchronous to clk_i |
| los_mask_i | input | 1 | Host mask; 1 blocks LOS change interrupts |
| int_clr_i | input | 1 | Host pulse clearing the pending interrupt |
| tx_hiz_req_i | input | 1 | Host request to put the driver in high impedance |
| los_o | output | 1 | Loss-of-signal flag |
| irq_o | output | 1 | Pending LOS-change interrupt level |
| drv_off_o | output | 1 | Transmit driver disable (high impedance) |

## Verification
The embedded assertions check these rules on every cycle:
- the loss flag rises only on a strobed zero and falls after any strobed mark;
- an unmasked flag change always leaves the interrupt pending on the next cycle;
- a masked change never sets it;
- the driver disable rises only when the watchdog count is full, and a synchronized rising edge always clears it;
- the host high-impedance request always forces the disable.

Some behaviour only the bench scenarios can show:
- the exact run lengths of 174 and 175 zeros;
- recovery through either rail;
- that the interrupt holds until it is cleared;
- the stop-to-disable window of the transmit clock;
- the re-enable latency once the clock returns.

// File: rtl/los_pkg.sv
package los_pkg;
  function automatic int cnt_w(input int limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/los_zero_det.sv
module los_zero_det #(
  parameter int ZERO_LIMIT = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic mark_i,
  output logic los_o
);
  localparam int CW = los_pkg::cnt_w(ZERO_LIMIT);

  logic [CW-1:0] run_q;
  logic          los_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      los_q <= 1'b0;
    end else if (strobe_i) begin
      if (mark_i) begin
        run_q <= '0;
        los_q <= 1'b0;
      end else if (run_q != CW'(ZERO_LIMIT)) begin
        run_q <= run_q + 1'b1;
        if (run_q == CW'(ZERO_LIMIT - 1)) los_q <= 1'b1;
      end
    end
  end

  assign los_o = los_q;

  // R1
  los_rise_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_q) |-> $past(strobe_i && !mark_i));
  // R2
  mark_clears_los_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mark_i) |=> !los_q);
endmodule

// File: rtl/los_irq.sv
module los_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic los_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic irq_o
);
  logic los_d_q;
  logic pend_q;
  logic chg;

  assign chg = (los_i != los_d_q) && !mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      los_d_q <= los_i;
      if (chg)        pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q;

  // R3
  change_sets_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i != los_d_q && !mask_i) |=> pend_q);
  // R5
  masked_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/tx_clk_wd.sv
module tx_clk_wd #(
  parameter int WD_LIMIT    = 700,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_clk_i,
  output logic dead_o
);
  localparam int CW = los_pkg::cnt_w(WD_LIMIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise;
  logic [CW-1:0]          gap_q;
  logic                   dead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tx_clk_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] && !last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      dead_q <= 1'b0;
    end else if (rise) begin
      gap_q  <= '0;
      dead_q <= 1'b0;
    end else if (gap_q != CW'(WD_LIMIT)) begin
      gap_q <= gap_q + 1'b1;
      if (gap_q == CW'(WD_LIMIT - 1)) dead_q <= 1'b1;
    end
  end

  assign dead_o = dead_q;

  // R6
  dead_needs_full_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dead_q) |-> gap_q == CW'(WD_LIMIT));
  // R7
  edge_revives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !dead_q);
endmodule

// File: rtl/los_txmon.sv
module los_txmon #(
  parameter int ZERO_LIMIT  = 175,
  parameter int REF_PER_UI  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_strobe_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  input  logic tx_clk_i,
  input  logic los_mask_i,
  input  logic int_clr_i,
  input  logic tx_hiz_req_i,
  output logic los_o,
  output logic irq_o,
  output logic drv_off_o
);
  localparam int WD_LIMIT = ZERO_LIMIT * REF_PER_UI;

  logic los;
  logic dead;

  los_zero_det #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(rx_strobe_i),
    .mark_i(rx_pos_i | rx_neg_i), .los_o(los)
  );

  los_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .los_i(los), .mask_i(los_mask_i),
    .clr_i(int_clr_i), .irq_o(irq_o)
  );

  tx_clk_wd #(.WD_LIMIT(WD_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_wd (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_clk_i(tx_clk_i), .dead_o(dead)
  );

  assign los_o     = los;
  assign drv_off_o = dead | tx_hiz_req_i;

  // R8
  hiz_req_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hiz_req_i |-> drv_off_o);
endmodule

// File: tb/tb_los_txmon.sv
module tb_los_txmon;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 5;
  localparam int unsigned zeros_tab [N_VEC] = '{174, 175, 1, 176, 400};
  localparam bit          rail_tab  [N_VEC] = '{0, 1, 0, 1, 1};
  localparam bit          exp_tab   [N_VEC] = '{0, 1, 0, 1, 1};

  logic clk = 0, rst_ni = 0;
  logic rx_strobe_i = 0, rx_pos_i = 0, rx_neg_i = 0;
  logic tx_clk_i = 0, tx_run = 1;
  logic los_mask_i = 0, int_clr_i = 0, tx_hiz_req_i = 0;
  logic los_o, irq_o, drv_off_o;
  int total = 0, bad = 0;

  los_txmon dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_strobe_i(rx_strobe_i), .rx_pos_i(rx_pos_i),
    .rx_neg_i(rx_neg_i), .tx_clk_i(tx_clk_i), .los_mask_i(los_mask_i),
    .int_clr_i(int_clr_i), .tx_hiz_req_i(tx_hiz_req_i),
    .los_o(los_o), .irq_o(irq_o), .drv_off_o(drv_off_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin
    #(CLK_PERIOD*2);
    if (tx_run) tx_clk_i = ~tx_clk_i;
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    rx_strobe_i = 1; rx_pos_i = p; rx_neg_i = n;
    @(negedge clk);
    rx_strobe_i = 0; rx_pos_i = 0; rx_neg_i = 0;
  endtask

  task automatic zeros(input int n);
    @(negedge clk);
    rx_strobe_i = 1;
    repeat (n) @(negedge clk);
    rx_strobe_i = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk); int_clr_i = 1;
    @(negedge clk); int_clr_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 los", los_o, 0);
    check("R9 irq", irq_o, 0);
    check("R9 drv", drv_off_o, 0);
    rst_ni = 1;
    repeat (20) @(negedge clk);

    // R1 R2 vector table: mark on chosen rail, then zero run
    for (int i = 0; i < N_VEC; i++) begin
      send_bit(!rail_tab[i], rail_tab[i]);
      check("R2 mark clears", los_o, 0);
      zeros(zeros_tab[i]);
      check("R1 zero run", los_o, exp_tab[i]);
    end
    // R1 gaps without strobe not counted
    send_bit(1, 0);
    zeros(100);
    repeat (200) @(negedge clk);
    zeros(74);
    check("R1 unstrobed gap", los_o, 0);
    zeros(1);
    check("R1 175th", los_o, 1);
    @(negedge clk);
    clear_irq();
    check("R4 cleared", irq_o, 0);

    // R3 fall sets irq; R4 held until clear
    send_bit(0, 1);
    check("R2 neg rail", los_o, 0);
    @(negedge clk);
    check("R3 fall irq", irq_o, 1);
    repeat (10) @(negedge clk);
    check("R4 held", irq_o, 1);
    clear_irq();
    check("R4 clear", irq_o, 0);
    zeros(175);
    @(negedge clk);
    check("R3 rise irq", irq_o, 1);
    clear_irq();

    // R5 masked
    los_mask_i = 1;
    send_bit(1, 0);
    check("R5 los follows", los_o, 0);
    repeat (3) @(negedge clk);
    check("R5 no irq fall", irq_o, 0);
    zeros(175);
    repeat (3) @(negedge clk);
    check("R5 los set", los_o, 1);
    check("R5 no irq rise", irq_o, 0);
    los_mask_i = 0;
    send_bit(1, 0);

    // R6 tx clock running keeps driver on, then stops
    repeat (1000) @(negedge clk);
    check("R6 running", drv_off_o, 0);
    tx_run = 0;
    repeat (650) @(negedge clk);
    check("R6 before limit", drv_off_o, 0);
    repeat (70) @(negedge clk);
    check("R6 after limit", drv_off_o, 1);
    // R7 return of clock
    tx_run = 1;
    repeat (10) @(negedge clk);
    check("R7 revive", drv_off_o, 0);

    // R8 host request
    @(negedge clk); tx_hiz_req_i = 1;
    #1 check("R8 forced", drv_off_o, 1);
    @(negedge clk); tx_hiz_req_i = 0;
    #1 check("R8 released", drv_off_o, 0);

    // R9 mid-run reset
    zeros(175);
    rst_ni = 0;
    @(negedge clk);
    check("R9 los reset", los_o, 0);
    check("R9 irq reset", irq_o, 0);
    rst_ni = 1;
    zeros(174);
    check("R9 counter cleared", los_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule